// File: doc/BRIEF.md
# Shadowed Channel Setting Controller

This block holds the settings for a bank of output channels. Each channel has a working byte that drives its output code and a backing byte in nonvolatile storage. The nonvolatile storage is modelled here as a register array with a write strobe, and it comes out of power-up holding a factory value of 80h. A reset copies every backing byte into its working byte, so the outputs come back at the last saved setting.

A serial front end sits in front of the block. It delivers decoded bus events to the block as one-cycle pulses for start, stop and abort, and it delivers each received address/data pair as a staged write. The block keeps up to four staged writes and applies them together in the cycle of the stop pulse. A start or an abort throws the staged writes away. A control byte carries a mode flag. While the flag is clear, a committed channel write is also saved to nonvolatile storage, and a busy timer then runs so that the front end can refuse its bus address until the slow storage write is finished. While the flag is set, only the working byte changes. The read port returns working bytes, so reads never come from storage.

Top module: `shadow_setting_ctrl`

## Requirements
- R1: A reset loads each channel's output code from its nonvolatile byte, clears the mode flag and clears busy. Before any save, every nonvolatile byte holds 80h.
- R2: A staged write changes neither the outputs nor the read data before the stop pulse. The stop pulse applies all staged writes at the clock edge where it is sampled.
- R3: With the mode flag at 0, a committed write to channel address 00h to 07h also updates that channel's nonvolatile byte, so the value is still there after a later reset.
- R4: With the mode flag at 1, a committed channel write updates only the working byte, so a later reset restores the previous nonvolatile value.
- R5: The mode flag in effect before a commit decides how every channel byte of that commit is handled, even when the same commit also writes the control byte.
- R6: A read of 00h to 07h returns the working byte. A read of the control byte at 08h returns the mode flag in bit 7 and zeros in bits 6 to 0. A read of 09h to FFh returns 00h.
- R7: A committed write to an address from 09h to FFh changes no output, no readable byte and no nonvolatile byte, and it does not start the busy timer.
- R8: A start pulse or an abort pulse discards all staged writes, so a stop that follows applies nothing.
- R9: At most four writes are staged per transaction, and further writes are dropped. When two staged writes have the same address, the later one wins.
- R10: A commit that saves at least one channel byte drives busy high for exactly BUSY_CYCLES clock cycles, starting after the commit edge. A commit that saves nothing leaves busy low.
- R11: Changing the mode flag leaves every working byte and every nonvolatile byte as it was.
- R12: A staged write presented in the same cycle as a start, stop or abort pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads working bytes from storage |
| fe_start | input | 1 | Start or repeated start seen on the bus (one-cycle pulse) |
| fe_stop | input | 1 | Stop seen on the bus; commits the staged writes |
| fe_abort | input | 1 | Transfer aborted; discards the staged writes |
| fe_wr_valid | input | 1 | Stage one received address/data pair |
| fe_wr_addr | input | 8 | Register address of the staged write |
| fe_wr_data | input | 8 | Data byte of the staged write |
| fe_rd_addr | input | 8 | Read address |
| fe_rd_data | output | 8 | Read data for fe_rd_addr (combinational) |
| busy | output | 1 | Nonvolatile save in progress |
| code_out | output | NUM_CH*8 | Output codes; channel c in bits [8c+7:8c] |

## Verification
The bench builds the block with its default eight channels and four staging slots, and with BUSY_CYCLES set to 20. The short timer means every busy window can be counted edge by edge, and the bench can wait out many saves within a short run. With this setup the bench sweeps all 256 read addresses and several full-bank save and reset cycles that touch every channel. It also covers the corner cases of one transaction: overflow of the staging buffer, duplicate addresses, discard by start and by abort, a control-byte write mixed with channel writes, and a staged write that collides with a pulse.

// File: rtl/shadow_set_pkg.sv
package shadow_set_pkg;

    localparam int          BYTE_W       = 8;
    localparam logic [7:0]  CTRL_ADDR    = 8'h08;
    localparam int          MODE_POS     = 7;
    localparam logic [7:0]  FACTORY_CODE = 8'h80;

    typedef struct packed {
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } stage_t;

    function automatic logic is_chan(input logic [BYTE_W-1:0] a, input int nch);
        return int'(a) < nch;
    endfunction

endpackage

// File: rtl/stage_buffer.sv
module stage_buffer
    import shadow_set_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                push,
    input  stage_t              push_entry,
    output stage_t [DEPTH-1:0]  entries,
    output logic   [DEPTH-1:0]  valid
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0]    fill_q;
    stage_t [DEPTH-1:0]  ent_q;
    logic   [DEPTH-1:0]  val_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fill_q <= '0;
            val_q  <= '0;
        end else if (push && (fill_q < CNT_W'(DEPTH))) begin
            ent_q[fill_q[IDX_W-1:0]] <= push_entry;
            val_q[fill_q[IDX_W-1:0]] <= 1'b1;
            fill_q                   <= fill_q + 1'b1;
        end
    end

    assign entries = ent_q;
    assign valid   = val_q;

endmodule

// File: rtl/nv_array.sv
module nv_array
    import shadow_set_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                           clk,
    input  logic [NUM_CH-1:0]              we,
    input  logic [NUM_CH-1:0][BYTE_W-1:0]  wdata,
    output logic [NUM_CH-1:0][BYTE_W-1:0]  rdata
);
    // Storage keeps its contents across rst; only the initial value is set.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cell
        logic [BYTE_W-1:0] cell_q = FACTORY_CODE;
        always_ff @(posedge clk) begin
            if (we[g]) cell_q <= wdata[g];
        end
        assign rdata[g] = cell_q;
    end

endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
    parameter int CYCLES = 4_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (load)          left_q <= CNT_W'(CYCLES);
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);

endmodule

// File: rtl/shadow_setting_ctrl.sv
module shadow_setting_ctrl
    import shadow_set_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int DEPTH       = 4,
    parameter int BUSY_CYCLES = 4_000_000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fe_start,
    input  logic                       fe_stop,
    input  logic                       fe_abort,
    input  logic                       fe_wr_valid,
    input  logic [7:0]                 fe_wr_addr,
    input  logic [7:0]                 fe_wr_data,
    input  logic [7:0]                 fe_rd_addr,
    output logic [7:0]                 fe_rd_data,
    output logic                       busy,
    output logic [NUM_CH*BYTE_W-1:0]   code_out
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    stage_t [DEPTH-1:0]               st_entries;
    logic   [DEPTH-1:0]               st_valid;
    logic                             st_clear;
    logic [NUM_CH-1:0][BYTE_W-1:0]    work_q;
    logic [NUM_CH-1:0][BYTE_W-1:0]    nv_rd;
    logic [NUM_CH-1:0][BYTE_W-1:0]    nv_wd;
    logic [NUM_CH-1:0]                nv_we;
    logic                             mode_q;

    assign st_clear = fe_start | fe_abort | fe_stop;

    stage_buffer #(.DEPTH(DEPTH)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .clear      (st_clear),
        .push       (fe_wr_valid),
        .push_entry ('{addr: fe_wr_addr, data: fe_wr_data}),
        .entries    (st_entries),
        .valid      (st_valid)
    );

    nv_array #(.NUM_CH(NUM_CH)) u_nv (
        .clk   (clk),
        .we    (nv_we),
        .wdata (nv_wd),
        .rdata (nv_rd)
    );

    busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk  (clk),
        .rst  (rst),
        .load (|nv_we),
        .busy (busy)
    );

    // Save path: uses the mode flag held before this commit; later slot wins.
    always_comb begin
        nv_we = '0;
        nv_wd = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (fe_stop && !rst && !mode_q && st_valid[k] &&
                    (st_entries[k].addr == 8'(c))) begin
                    nv_we[c] = 1'b1;
                    nv_wd[c] = st_entries[k].data;
                end
            end
        end
    end

    // Working bytes and control flag
    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= nv_rd;
            mode_q <= 1'b0;
        end else if (fe_stop) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (st_valid[k]) begin
                    if (is_chan(st_entries[k].addr, NUM_CH))
                        work_q[st_entries[k].addr[CH_W-1:0]] <= st_entries[k].data;
                    else if (st_entries[k].addr == CTRL_ADDR)
                        mode_q <= st_entries[k].data[MODE_POS];
                end
            end
        end
    end

    // Read port
    always_comb begin
        fe_rd_data = '0;
        if (is_chan(fe_rd_addr, NUM_CH))
            fe_rd_data = work_q[fe_rd_addr[CH_W-1:0]];
        else if (fe_rd_addr == CTRL_ADDR)
            fe_rd_data[MODE_POS] = mode_q;
    end

    assign code_out = work_q;

endmodule

// File: rtl/shadow_set_chk.sv
module shadow_set_chk
    import shadow_set_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int BUSY_CYCLES = 4_000_000
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      fe_stop,
    input logic [7:0]                fe_rd_addr,
    input logic [7:0]                fe_rd_data,
    input logic                      busy,
    input logic [NUM_CH*BYTE_W-1:0]  code_out,
    input logic                      mode_q,
    input logic [NUM_CH-1:0]         nv_we
);
    int run_q;

    always_ff @(posedge clk) begin
        if (rst)              run_q <= 0;
        else if (|nv_we)      run_q <= 0;
        else if (busy)        run_q <= run_q + 1;
    end

    // R2
    hold_codes_chk: assert property (@(posedge clk) disable iff (rst)
        !fe_stop |=> $stable(code_out));

    // R4
    no_save_in_mode1_chk: assert property (@(posedge clk) disable iff (rst)
        mode_q |-> (nv_we == '0));

    // R10
    busy_after_save_chk: assert property (@(posedge clk) disable iff (rst)
        (nv_we != '0) |=> busy);

    // R10
    busy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(nv_we != '0));

    // R10
    busy_length_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> (run_q == BUSY_CYCLES));

    // R6
    empty_space_read_chk: assert property (@(posedge clk) disable iff (rst)
        (fe_rd_addr > CTRL_ADDR) |-> (fe_rd_data == 8'h00));

endmodule

bind shadow_setting_ctrl shadow_set_chk #(
    .NUM_CH      (NUM_CH),
    .BUSY_CYCLES (BUSY_CYCLES)
) u_shadow_set_chk (
    .clk        (clk),
    .rst        (rst),
    .fe_stop    (fe_stop),
    .fe_rd_addr (fe_rd_addr),
    .fe_rd_data (fe_rd_data),
    .busy       (busy),
    .code_out   (code_out),
    .mode_q     (mode_q),
    .nv_we      (nv_we)
);

// File: tb/test_shadow_setting_ctrl.sv
`timescale 1ns/1ps
module test_shadow_setting_ctrl;

    localparam int NCH  = 8;
    localparam int DPT  = 4;
    localparam int BUSY = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fe_start = 0, fe_stop = 0, fe_abort = 0, fe_wr_valid = 0;
    logic [7:0] fe_wr_addr = 0, fe_wr_data = 0, fe_rd_addr = 0;
    logic [7:0] fe_rd_data;
    logic busy;
    logic [NCH*8-1:0] code_out;

    always #2.5 clk = ~clk;

    shadow_setting_ctrl #(.NUM_CH(NCH), .DEPTH(DPT), .BUSY_CYCLES(BUSY)) i_shadow_setting_ctrl (
        .clk(clk), .rst(rst), .fe_start(fe_start), .fe_stop(fe_stop), .fe_abort(fe_abort),
        .fe_wr_valid(fe_wr_valid), .fe_wr_addr(fe_wr_addr), .fe_wr_data(fe_wr_data),
        .fe_rd_addr(fe_rd_addr), .fe_rd_data(fe_rd_data), .busy(busy), .code_out(code_out)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    logic [7:0] exp_work [NCH];
    logic [7:0] exp_nv   [NCH];
    logic       exp_mode;
    logic [7:0] sa [DPT];
    logic [7:0] sd [DPT];
    int         sn;
    logic       exp_busy;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_codes(input string req);
        for (int c = 0; c < NCH; c++) chk(req, code_out[c*8 +: 8], exp_work[c]);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        fe_rd_addr = a;
        #0.5;
        d = fe_rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        for (int c = 0; c < NCH; c++) exp_work[c] = exp_nv[c];
        exp_mode = 0;
        sn = 0;
    endtask

    task automatic stage(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        fe_wr_valid = 1; fe_wr_addr = a; fe_wr_data = d;
        @(negedge clk);
        fe_wr_valid = 0;
        if (sn < DPT) begin sa[sn] = a; sd[sn] = d; sn++; end
    endtask

    // kind: 0 start, 1 stop, 2 abort; returns at the negedge after the edge
    task automatic pulse(input int kind);
        logic m;
        @(negedge clk);
        case (kind)
            0: fe_start = 1;
            1: fe_stop  = 1;
            default: fe_abort = 1;
        endcase
        @(negedge clk);
        fe_start = 0; fe_stop = 0; fe_abort = 0;
        exp_busy = 0;
        if (kind == 1) begin
            m = exp_mode;
            for (int k = 0; k < sn; k++) begin
                if (sa[k] < NCH) begin
                    exp_work[sa[k]] = sd[k];
                    if (!m) begin exp_nv[sa[k]] = sd[k]; exp_busy = 1; end
                end else if (sa[k] == 8'h08) exp_mode = sd[k][7];
            end
        end
        sn = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic count_busy(input string req);
        int n = 0;
        while (busy && n < 1000) begin @(negedge clk); n++; end
        chk(req, n, BUSY);
    endtask

    initial begin
        logic [7:0] d;
        for (int c = 0; c < NCH; c++) exp_nv[c] = 8'h80;
        do_reset();

        // R1: reset state
        check_codes("R1 reset codes");
        chk("R1 busy after reset", busy, 0);
        rd(8'h08, d); chk("R1 mode cleared", d, 8'h00);

        // R6: sweep of all read addresses
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), d);
            if (a < NCH) chk("R6 channel read", d, exp_work[a]);
            else if (a == 8) chk("R6 ctrl read", d, {exp_mode, 7'b0});
            else chk("R6 empty read", d, 8'h00);
        end

        // R2: staged writes invisible until stop
        stage(8'h00, 8'h11);
        stage(8'h01, 8'h22);
        check_codes("R2 before stop");
        rd(8'h00, d); chk("R2 read before stop", d, 8'h80);
        pulse(1);
        check_codes("R2 after stop");
        rd(8'h01, d); chk("R2 read after stop", d, 8'h22);
        chk("R10 busy after save", busy, 1);
        count_busy("R10 busy length");

        // R3: saved values survive reset
        do_reset();
        check_codes("R3 survive reset");

        // R11, R6: set mode flag, reserved bits read zero
        stage(8'h08, 8'hFF);
        pulse(1);
        rd(8'h08, d); chk("R6 ctrl reserved zero", d, 8'h80);
        chk("R10 ctrl-only no busy", busy, 0);
        check_codes("R11 mode change keeps data");

        // R4: volatile-only write
        stage(8'h02, 8'h33);
        pulse(1);
        chk("R4 no busy in mode1", busy, 0);
        check_codes("R4 working updated");
        do_reset();
        check_codes("R4 reverted after reset");
        rd(8'h08, d); chk("R1 mode back to 0", d, 8'h00);

        // R11: clearing mode from 1 to 0 keeps data
        stage(8'h08, 8'h80); pulse(1);
        stage(8'h03, 8'h3C); pulse(1);
        stage(8'h08, 8'h00); pulse(1);
        check_codes("R11 clear mode keeps data");
        chk("R11 no busy", busy, 0);
        do_reset();
        check_codes("R11 nv untouched");

        // R8: discard by start and by abort
        stage(8'h03, 8'h44);
        pulse(0);
        pulse(1);
        check_codes("R8 start discards");
        chk("R10 empty stop no busy", busy, 0);
        stage(8'h03, 8'h45);
        pulse(2);
        pulse(1);
        check_codes("R8 abort discards");

        // R9: overflow and duplicates
        for (int k = 0; k < 5; k++) stage(8'(k), 8'hA0 + 8'(k));
        pulse(1);
        check_codes("R9 fifth write dropped");
        chk("R9 ch4 unchanged", code_out[4*8 +: 8], 8'h80);
        wait_idle();
        stage(8'h05, 8'h01);
        stage(8'h05, 8'h02);
        pulse(1);
        chk("R9 later wins", code_out[5*8 +: 8], 8'h02);
        wait_idle();
        do_reset();
        check_codes("R9 later wins saved");

        // R7: writes to empty space ignored
        stage(8'h09, 8'h55);
        stage(8'hFF, 8'h66);
        pulse(1);
        check_codes("R7 codes unchanged");
        chk("R7 no busy", busy, 0);
        rd(8'h09, d); chk("R7 read 09", d, 0);
        rd(8'hFF, d); chk("R7 read FF", d, 0);
        rd(8'h08, d); chk("R7 ctrl untouched", d, 0);
        do_reset();
        check_codes("R7 nv untouched");

        // R5: mode before commit governs channel bytes
        stage(8'h08, 8'h80);
        stage(8'h06, 8'h77);
        pulse(1);
        chk("R5 saved with old mode", busy, 1);
        rd(8'h08, d); chk("R5 mode now set", d, 8'h80);
        wait_idle();
        do_reset();
        check_codes("R5 channel saved");

        // R12: write colliding with a pulse is dropped
        @(negedge clk);
        fe_wr_valid = 1; fe_wr_addr = 8'h01; fe_wr_data = 8'hEE; fe_stop = 1;
        @(negedge clk);
        fe_wr_valid = 0; fe_stop = 0;
        pulse(1);
        check_codes("R12 colliding write dropped");
        chk("R12 no busy", busy, 0);

        // R3: full-bank save and restore sweeps
        foreach (sa[i]) sa[i] = 0;
        for (int p = 0; p < 3; p++) begin
            logic [7:0] base;
            base = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'h5A;
            for (int pg = 0; pg < NCH; pg += DPT) begin
                for (int k = 0; k < DPT; k++) stage(8'(pg + k), base ^ 8'(pg + k));
                pulse(1);
                wait_idle();
            end
            do_reset();
            check_codes("R3 bank sweep");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule